// File: doc/BRIEF.md
# Cartridge ROM Bank Controller

This block sits between a processor's 16-bit address bus and an external ROM that is larger than the processor can address directly. Writes into the lower half of the address space (0x0000–0x7FFF) do not reach the ROM. The controller decodes them as updates to its control state: a RAM-enable flag, a 5-bit ROM bank number, a 2-bit secondary bank number and a banking-mode bit.

Reads in the fixed window 0x0000–0x3FFF reach the first 16 KiB of ROM unchanged. Reads in the switchable window 0x4000–0x7FFF produce a wide ROM offset from three fields. The secondary bank is placed above the ROM bank, and the ROM bank sits above the 14-bit window offset. The lowest bank bit is always forced to one, and the mode bit suppresses the secondary field.

A configured ROM size marks banked offsets that fall outside the device. For those offsets the controller reports a miss and returns zero data. The secondary bank number is exported for a separate RAM path. Two one-cycle pulses announce writes to the two bank registers.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, the ROM bank, secondary bank, mode bit and RAM-enable flag are all zero, and both write pulses are low. A banked read then uses bank number 1.
- R2: A write with address bits [15:13] = 001 (0x2000–0x3FFF) stores data bits [4:0] as the ROM bank. `rom_bank_wr` is high in the cycle after the write edge.
- R3: A write with address bits [15:13] = 010 (0x4000–0x5FFF) stores data bits [1:0] as the secondary bank, shown on `ram_bank`. `sec_bank_wr` is high in the cycle after the write edge.
- R4: A write with address bits [15:13] = 011 (0x6000–0x7FFF) loads data bit 0 into `bank_mode`.
- R5: A write with address bits [15:13] = 000 (0x0000–0x1FFF) sets `ram_en` when data bits [3:0] equal 0xA, and clears it otherwise.
- R6: A read with address bits [15:14] = 00 gives `rom_addr` equal to the address zero-extended, with `rom_hit` = 1 and `rd_data` = `rom_rdata`.
- R7: A read with address bits [15:14] = 01 gives a `rom_addr` made of three fields. Bits [13:0] are the address bits [13:0]. Bits [18:14] are the ROM bank OR 1. Bits [20:19] are the secondary bank.
- R8: While `bank_mode` is 1, bits [20:19] of a banked `rom_addr` are zero.
- R9: The controller reports a miss (`rom_hit` = 0, `rd_data` = 0x00) in two cases. One is a banked read whose offset is at or above `cfg_rom_bytes`. The other is any read with address bit 15 set.
- R10: A cycle with `cpu_wr` low, or with address bit 15 set, changes no control state and raises no pulse.
- R11: Each bank write pulse lasts exactly one cycle per write and is low in the following idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| cpu_wdata | input | 8 | Write data |
| cfg_rom_bytes | input | 22 | Size of the attached ROM in bytes |
| rom_rdata | input | 8 | Data returned by the ROM for `rom_addr` |
| rom_addr | output | 21 | ROM byte offset for the current address |
| rom_hit | output | 1 | Offset lies inside the ROM |
| rd_data | output | 8 | Read data, zero on a miss |
| ram_bank | output | 2 | Secondary bank number |
| ram_en | output | 1 | RAM-enable flag |
| bank_mode | output | 1 | Banking mode bit |
| rom_bank_wr | output | 1 | One-cycle pulse after a ROM bank write |
| sec_bank_wr | output | 1 | One-cycle pulse after a secondary bank write |

## Verification
A corrupted ROM bank register never reaches a port directly. It appears as a wrong field in bits [18:14] of `rom_addr` on the first banked read after the fault, in the same cycle as that read. A bad secondary bank or mode bit shows at once on `ram_bank` or `bank_mode`. It also appears in the top field of the next banked offset, and it can flip `rom_hit` near the configured size. The bench therefore follows each control write with banked reads, and it places reads on both sides of the size boundary.

// File: rtl/cart_bank_pkg.sv
// Shared definitions for the cartridge bank controller.
// Assumes the control region is the lower half of the processor space and is
// split into four equal slices selected by the two address bits under the MSB.
package cart_bank_pkg;

    // Control slice selected by address bits [MSB-1:MSB-2] on a write
    typedef enum logic [1:0] {
        CTL_RAM_GATE = 2'b00,
        CTL_ROM_SEL  = 2'b01,
        CTL_SEC_SEL  = 2'b10,
        CTL_MODE_SEL = 2'b11
    } ctl_slice_e;

    // Nibble value that opens the RAM gate
    localparam logic [3:0] RAM_OPEN_KEY = 4'hA;

endpackage

// File: rtl/cart_bank_regs.sv
// Control register file: decodes processor writes in the lower half of the
// address space into the RAM gate, the ROM bank, the secondary bank and the
// mode bit, and raises a one-cycle pulse after each bank-register write.
// Assumes DATA_W >= BANK_W, DATA_W >= SEC_W and DATA_W >= 4.
module cart_bank_regs
    import cart_bank_pkg::*;
#(
    parameter int CPU_AW = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 5,
    parameter int SEC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BANK_W-1:0] rom_bank,
    output logic [SEC_W-1:0]  sec_bank,
    output logic              mode,
    output logic              ram_gate,
    output logic              rom_pulse,
    output logic              sec_pulse
);

    logic       ctl_write;
    ctl_slice_e slice;

    // Qualify writes that land in the control half and pick their slice
    always_comb begin
        ctl_write = wr_en && !wr_addr[CPU_AW-1];
        slice     = ctl_slice_e'(wr_addr[CPU_AW-2 -: 2]);
    end

    // Update control state and produce the write pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_bank  <= '0;
            sec_bank  <= '0;
            mode      <= 1'b0;
            ram_gate  <= 1'b0;
            rom_pulse <= 1'b0;
            sec_pulse <= 1'b0;
        end else begin
            rom_pulse <= 1'b0;
            sec_pulse <= 1'b0;
            if (ctl_write) begin
                unique case (slice)
                    CTL_RAM_GATE: ram_gate <= (wr_data[3:0] == RAM_OPEN_KEY);
                    CTL_ROM_SEL: begin
                        rom_bank  <= wr_data[BANK_W-1:0];
                        rom_pulse <= 1'b1;
                    end
                    CTL_SEC_SEL: begin
                        sec_bank  <= wr_data[SEC_W-1:0];
                        sec_pulse <= 1'b1;
                    end
                    CTL_MODE_SEL: mode <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cart_bank_map.sv
// Address former: passes the fixed window through and builds the banked
// offset as {secondary, bank | 1, window offset}, suppressing the secondary
// field while the mode bit is set. Purely combinational.
// Assumes the switchable window is the second quarter of the processor space.
module cart_bank_map #(
    parameter int CPU_AW = 16,
    parameter int BANK_W = 5,
    parameter int SEC_W  = 2,
    localparam int WIN_W  = CPU_AW - 2,
    localparam int ROM_AW = WIN_W + BANK_W + SEC_W
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BANK_W-1:0] rom_bank,
    input  logic [SEC_W-1:0]  sec_bank,
    input  logic              mode,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              in_rom,
    output logic              banked
);

    logic [WIN_W-1:0]  win_ofs;
    logic [BANK_W-1:0] bank_eff;
    logic [SEC_W-1:0]  sec_eff;

    // Classify the address and form the effective fields
    always_comb begin
        win_ofs  = cpu_addr[WIN_W-1:0];
        in_rom   = !cpu_addr[CPU_AW-1];
        banked   = in_rom && cpu_addr[CPU_AW-2];
        bank_eff = rom_bank | BANK_W'(1);
        sec_eff  = mode ? '0 : sec_bank;
    end

    // Select fixed or banked offset
    always_comb begin
        if (banked) begin
            rom_addr = {sec_eff, bank_eff, win_ofs};
        end else begin
            rom_addr = ROM_AW'(win_ofs);
        end
    end

endmodule

// File: rtl/cart_bank_guard.sv
// Range guard: compares a banked offset with the configured ROM size and
// zeroes the returned data on a miss. The fixed window always hits.
// Assumes the configured size covers at least the fixed window.
module cart_bank_guard #(
    parameter int ROM_AW = 21,
    parameter int DATA_W = 8
) (
    input  logic [ROM_AW-1:0] rom_addr,
    input  logic              in_rom,
    input  logic              banked,
    input  logic [ROM_AW:0]   rom_bytes,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data
);

    logic below_end;

    // Decide whether the offset lies inside the ROM
    always_comb begin
        below_end = {1'b0, rom_addr} < rom_bytes;
        hit       = in_rom && (!banked || below_end);
    end

    // Gate the ROM data with the hit decision
    always_comb begin
        rd_data = hit ? rom_rdata : '0;
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
// Top level of the cartridge bank controller: control registers, address
// former and range guard. Reads are combinational from address to data;
// writes take effect on the next rising edge.
// Assumes an external ROM that answers rom_addr combinationally on rom_rdata.
module cart_bank_ctrl #(
    parameter int CPU_AW = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 5,
    parameter int SEC_W  = 2,
    localparam int WIN_W  = CPU_AW - 2,
    localparam int ROM_AW = WIN_W + BANK_W + SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [ROM_AW:0]   cfg_rom_bytes,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_hit,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEC_W-1:0]  ram_bank,
    output logic              ram_en,
    output logic              bank_mode,
    output logic              rom_bank_wr,
    output logic              sec_bank_wr
);

    logic [BANK_W-1:0] rom_bank_q;
    logic              in_rom;
    logic              banked;

    cart_bank_regs #(
        .CPU_AW (CPU_AW),
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .SEC_W  (SEC_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_wr),
        .wr_addr   (cpu_addr),
        .wr_data   (cpu_wdata),
        .rom_bank  (rom_bank_q),
        .sec_bank  (ram_bank),
        .mode      (bank_mode),
        .ram_gate  (ram_en),
        .rom_pulse (rom_bank_wr),
        .sec_pulse (sec_bank_wr)
    );

    cart_bank_map #(
        .CPU_AW (CPU_AW),
        .BANK_W (BANK_W),
        .SEC_W  (SEC_W)
    ) map_i (
        .cpu_addr (cpu_addr),
        .rom_bank (rom_bank_q),
        .sec_bank (ram_bank),
        .mode     (bank_mode),
        .rom_addr (rom_addr),
        .in_rom   (in_rom),
        .banked   (banked)
    );

    cart_bank_guard #(
        .ROM_AW (ROM_AW),
        .DATA_W (DATA_W)
    ) guard_i (
        .rom_addr  (rom_addr),
        .in_rom    (in_rom),
        .banked    (banked),
        .rom_bytes (cfg_rom_bytes),
        .rom_rdata (rom_rdata),
        .hit       (rom_hit),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
// Checker for the cartridge bank controller, attached by bind. Observes the
// top-level ports only.
module cart_bank_ctrl_chk #(
    parameter int CPU_AW = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 5,
    parameter int SEC_W  = 2,
    localparam int WIN_W  = CPU_AW - 2,
    localparam int ROM_AW = WIN_W + BANK_W + SEC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_hit,
    input logic [DATA_W-1:0] rd_data,
    input logic [SEC_W-1:0]  ram_bank,
    input logic              ram_en,
    input logic              bank_mode,
    input logic              rom_bank_wr,
    input logic              sec_bank_wr
);

    p_rom_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1 -: 3] == 3'b001) |=> rom_bank_wr);

    p_sec_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1 -: 3] == 3'b010)
        |=> (sec_bank_wr && ram_bank == $past(cpu_wdata[SEC_W-1:0])));

    p_mode_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1 -: 3] == 3'b011)
        |=> (bank_mode == $past(cpu_wdata[0])));

    p_ram_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1 -: 3] == 3'b000)
        |=> (ram_en == ($past(cpu_wdata[3:0]) == 4'hA)));

    p_fixed_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[CPU_AW-1 -: 2] == 2'b00)
        |-> (rom_hit && rom_addr == ROM_AW'(cpu_addr[WIN_W-1:0])));

    p_low_bank_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[CPU_AW-1 -: 2] == 2'b01)
        |-> (rom_addr[WIN_W] && rom_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]));

    p_mode_clears_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_mode && cpu_addr[CPU_AW-1 -: 2] == 2'b01)
        |-> (rom_addr[ROM_AW-1 -: SEC_W] == '0));

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_hit) |-> (rd_data == '0));

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && !cpu_addr[CPU_AW-1])
        |=> ($stable(ram_bank) && $stable(bank_mode) && $stable(ram_en)
             && !rom_bank_wr && !sec_bank_wr));

    p_pulse_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rom_bank_wr |-> $past(cpu_wr && cpu_addr[CPU_AW-1 -: 3] == 3'b001));

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
    .CPU_AW (CPU_AW),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .SEC_W  (SEC_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wr      (cpu_wr),
    .cpu_wdata   (cpu_wdata),
    .rom_addr    (rom_addr),
    .rom_hit     (rom_hit),
    .rd_data     (rd_data),
    .ram_bank    (ram_bank),
    .ram_en      (ram_en),
    .bank_mode   (bank_mode),
    .rom_bank_wr (rom_bank_wr),
    .sec_bank_wr (sec_bank_wr)
);

// File: tb/cart_bank_ctrl_tb_top.sv
// Scoreboard bench: driver tasks apply stimulus on the falling edge and push
// expected items; the monitor pops them 1 ns after the next rising edge.
module cart_bank_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [21:0] cfg_rom_bytes = 22'h040000;
    logic [7:0]  rom_rdata;
    logic [20:0] rom_addr;
    logic        rom_hit;
    logic [7:0]  rd_data;
    logic [1:0]  ram_bank;
    logic        ram_en;
    logic        bank_mode;
    logic        rom_bank_wr;
    logic        sec_bank_wr;

    always #2 clk = ~clk;

    // ROM model: data is a fixed function of the offset
    function automatic logic [7:0] rom_fn(input logic [20:0] a);
        return a[7:0] ^ a[20:13];
    endfunction

    assign rom_rdata = rom_fn(rom_addr);

    cart_bank_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_addr      (cpu_addr),
        .cpu_wr        (cpu_wr),
        .cpu_wdata     (cpu_wdata),
        .cfg_rom_bytes (cfg_rom_bytes),
        .rom_rdata     (rom_rdata),
        .rom_addr      (rom_addr),
        .rom_hit       (rom_hit),
        .rd_data       (rd_data),
        .ram_bank      (ram_bank),
        .ram_en        (ram_en),
        .bank_mode     (bank_mode),
        .rom_bank_wr   (rom_bank_wr),
        .sec_bank_wr   (sec_bank_wr)
    );

    typedef struct {
        string       req;
        bit          is_rd;
        logic [20:0] ea;
        bit          eh;
        logic [7:0]  ed;
        logic [1:0]  ebank;
        bit          emode;
        bit          eren;
        bit          epr;
        bit          eps;
    } item_t;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Reference state kept by the bench
    logic [4:0] m_bank = '0;
    logic [1:0] m_sec = '0;
    bit         m_mode = 1'b0;
    bit         m_ren = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic item_t state_item(input string req, input bit pr, input bit ps);
        item_t it;
        it.req = req; it.is_rd = 1'b0; it.ea = '0; it.eh = 1'b0; it.ed = '0;
        it.ebank = m_sec; it.emode = m_mode; it.eren = m_ren;
        it.epr = pr; it.eps = ps;
        return it;
    endfunction

    // Driver: one write cycle, expected state checked after the edge
    task automatic drive_wr(input logic [15:0] a, input logic [7:0] d,
                            input bit en, input string req);
        bit pr;
        bit ps;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = en;
        pr = 1'b0; ps = 1'b0;
        if (en && !a[15]) begin
            case (a[14:13])
                2'b00: m_ren = (d[3:0] == 4'hA);
                2'b01: begin m_bank = d[4:0]; pr = 1'b1; end
                2'b10: begin m_sec = d[1:0]; ps = 1'b1; end
                default: m_mode = d[0];
            endcase
        end
        q.push_back(state_item(req, pr, ps));
    endtask

    // Driver: idle cycle, no pulses expected
    task automatic drive_idle(input string req);
        @(negedge clk);
        cpu_wr = 1'b0;
        q.push_back(state_item(req, 1'b0, 1'b0));
    endtask

    // Driver: combinational read
    task automatic drive_rd(input logic [15:0] a, input string req);
        item_t it;
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        it = state_item(req, 1'b0, 1'b0);
        it.is_rd = 1'b1;
        if (a[15]) begin
            it.ea = {7'd0, a[13:0]};
            it.eh = 1'b0;
        end else if (!a[14]) begin
            it.ea = {7'd0, a[13:0]};
            it.eh = 1'b1;
        end else begin
            it.ea = {(m_mode ? 2'b00 : m_sec), (m_bank | 5'd1), a[13:0]};
            it.eh = ({1'b0, it.ea} < cfg_rom_bytes);
        end
        it.ed = it.eh ? rom_fn(it.ea) : 8'h00;
        q.push_back(it);
    endtask

    // Monitor: compare outputs against queued expectations
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.is_rd) begin
                    chk(it.req, "rom_addr", 32'(rom_addr), 32'(it.ea));
                    chk(it.req, "rom_hit", 32'(rom_hit), 32'(it.eh));
                    chk(it.req, "rd_data", 32'(rd_data), 32'(it.ed));
                end else begin
                    chk(it.req, "ram_bank", 32'(ram_bank), 32'(it.ebank));
                    chk(it.req, "bank_mode", 32'(bank_mode), 32'(it.emode));
                    chk(it.req, "ram_en", 32'(ram_en), 32'(it.eren));
                    chk(it.req, "rom_bank_wr", 32'(rom_bank_wr), 32'(it.epr));
                    chk(it.req, "sec_bank_wr", 32'(sec_bank_wr), 32'(it.eps));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive_idle("R1");                  // reset state
        drive_rd(16'h4123, "R1");          // bank 0 maps as 1
        drive_rd(16'h0000, "R6");
        drive_rd(16'h3FFF, "R6");
        drive_wr(16'h2000, 8'hE2, 1'b1, "R2");   // bank 2
        drive_idle("R11");
        drive_rd(16'h5000, "R7");          // 2|1 = 3
        drive_wr(16'h3FFF, 8'h05, 1'b1, "R2");
        drive_rd(16'h7FFF, "R7");
        drive_wr(16'h4000, 8'hFE, 1'b1, "R3");   // secondary 2
        drive_idle("R11");
        drive_rd(16'h4000, "R9");          // beyond 256 KiB
        @(negedge clk) cfg_rom_bytes = 22'h200000;
        drive_rd(16'h4000, "R7");
        drive_wr(16'h6000, 8'h01, 1'b1, "R4");
        drive_rd(16'h4000, "R8");
        drive_wr(16'h7000, 8'h02, 1'b1, "R4");
        drive_rd(16'h4001, "R7");
        drive_wr(16'h0000, 8'h0A, 1'b1, "R5");
        drive_wr(16'h1FFF, 8'h1A, 1'b1, "R5");
        drive_wr(16'h1000, 8'h0B, 1'b1, "R5");
        drive_wr(16'h0000, 8'h5A, 1'b1, "R5");
        drive_wr(16'h8000, 8'h13, 1'b1, "R10");
        drive_wr(16'hA000, 8'h00, 1'b1, "R10");
        drive_wr(16'h2000, 8'h1F, 1'b0, "R10");
        drive_wr(16'h4000, 8'h03, 1'b0, "R10");
        drive_rd(16'h4000, "R10");         // bank still 5, secondary still 2
        drive_wr(16'h4000, 8'h00, 1'b1, "R3");
        @(negedge clk) cfg_rom_bytes = 22'h01C000;
        drive_wr(16'h2000, 8'h06, 1'b1, "R2");   // 6|1 = 7
        drive_rd(16'h4000, "R9");          // offset 0x1C000 = size
        drive_wr(16'h2000, 8'h04, 1'b1, "R2");   // 4|1 = 5
        drive_rd(16'h7FFF, "R9");          // 0x17FFF below size
        drive_rd(16'h9000, "R9");          // outside ROM space
        @(negedge clk) cfg_rom_bytes = 22'h200000;
        drive_wr(16'h2000, 8'h1F, 1'b1, "R2");
        drive_wr(16'h5FFF, 8'h03, 1'b1, "R3");
        drive_rd(16'h7FFF, "R7");          // top of 2 MiB
        drive_idle("R11");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule